// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block is the register file of one general-purpose I/O port, as wide as a whole number of byte lanes (32 pins by default). It sits on a simple memory-mapped bus with zero-wait-state reads. The bus gives a byte address and an access size of byte, half-word or word. Write data and read data sit in their natural lane positions. The block holds three stored registers: a direction register, a write/read mask and an output latch. It also offers three views of the output latch: a pin-value view, a set view and a clear view.

The mask is the central feature. A pin whose mask bit is 1 is frozen against pin-value, set and clear writes, and it reads back as 0 through the pin-value view. Software can therefore update a chosen subset of pins with a single store. The pin-value view returns the output latch for output pins. For input pins it returns the pad level after a two-flop synchroniser. Every register can be reached as a byte, a half-word or a word, so narrow stores touch only their own lanes.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted, and right after it, the direction register, the mask register and the output latch are zero. `pad_out` and `pad_oe` are therefore zero, and mask reads return 0.
- R2: Size code 0 is a byte, 1 is a half-word and 2 is a word. Byte lane k (pins 8k..8k+7) is at offset +k. Half-words are at +0 (pins 0-15) and +2 (pins 16-31). A word is at +0. Only the addressed lanes are written. Read data sits in lane position, and unaddressed lanes read 0.
- R3: An access with size code 3, a half-word at an odd offset, or a word at a non-zero offset is ignored. It changes no register and reads 0.
- R4: Word offsets are direction 0x00, mask 0x10, pin value 0x14 (so the mask sits 4 bytes below it), set 0x18 and clear 0x1C. Direction and mask read back as written. A direction bit of 1 makes the pin an output, and `pad_oe` equals the direction register.
- R5: A pin-value write loads the output latch from the write data, for bits that are unmasked and in an addressed lane.
- R6: A set write drives each unmasked, addressed latch bit written as 1 to 1. Bits written as 0 are unchanged.
- R7: A clear write drives each unmasked, addressed latch bit written as 1 to 0. Bits written as 0 are unchanged.
- R8: A latch bit whose mask bit is 1 does not change on pin-value, set or clear writes.
- R9: A pin-value read returns the latch for output pins and the synchronised pad level for input pins. The synchronised level follows `pad_in` two clock edges late. Masked bits read 0.
- R10: The set and clear offsets, and any unmapped offset, read 0. Writes to an unmapped offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the port |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data in lane position |
| bus_rdata | output | 32 | Read data in lane position, same cycle |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Output latch |
| pad_oe | output | 32 | Output enable per pin |

## Verification
The bench aims at the seams between the mask, the lanes and the direction split. It writes all ones through the pin-value view while the top byte is masked. A design that ignored the mask there would flip frozen pins, and one that forgot the mask on reads would show the latch in that byte. Narrow stores and reads at every lane and both half-word offsets expose a lane decoder that writes neighbouring bytes or shifts data out of lane position. Misaligned and invalid-size accesses would corrupt the latch in a decoder that trusted only the low address bits. The synchroniser check samples both one and two edges after a pad change, so a missing or extra flop shows up.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Byte lanes of the default port and byte address bits of the window
    localparam int PORT_LANES = 4;
    localparam int PORT_ADDR_W = 5;

    // Word index of each register (byte address divided by lane count)
    localparam logic [2:0] IDX_DIR  = 3'd0;
    localparam logic [2:0] IDX_MASK = 3'd4;
    localparam logic [2:0] IDX_PIN  = 3'd5;
    localparam logic [2:0] IDX_SET  = 3'd6;
    localparam logic [2:0] IDX_CLR  = 3'd7;

    // Access size codes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/gpio_lane_decode.sv
module gpio_lane_decode #(
    parameter int LANES = 4,
    parameter int OFS_W = $clog2(LANES)
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lane_en,
    output logic             aligned
);

    int span;
    int first;

    always_comb begin
        span    = 1 << int'(size);
        first   = int'(offset);
        aligned = (size != 2'd3) && (span <= LANES) && ((first % span) == 0);
        for (int i = 0; i < LANES; i++) begin
            lane_en[i] = aligned && (i >= first) && (i < first + span);
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stable;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int LANES  = PORT_LANES,
    parameter int ADDR_W = PORT_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [LANES*8-1:0] bus_wdata,
    output logic [LANES*8-1:0] bus_rdata,
    input  logic [LANES*8-1:0] pad_in,
    output logic [LANES*8-1:0] pad_out,
    output logic [LANES*8-1:0] pad_oe
);

    localparam int W     = LANES * 8;
    localparam int OFS_W = $clog2(LANES);
    localparam int IDX_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] mask;
        logic [W-1:0] outl;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [LANES-1:0] lane_en;
    logic             aligned;
    logic [W-1:0]     bit_en;
    logic [W-1:0]     open_bits;
    logic [W-1:0]     pin_sync;
    logic [W-1:0]     pin_view;
    logic [IDX_W-1:0] reg_idx;
    logic             do_wr;
    logic             do_rd;
    logic [W-1:0]     mask_view;

    assign reg_idx = bus_addr[ADDR_W-1:OFS_W];

    gpio_lane_decode #(.LANES(LANES), .OFS_W(OFS_W)) u_dec (
        .offset  (bus_addr[OFS_W-1:0]),
        .size    (bus_size),
        .lane_en (lane_en),
        .aligned (aligned)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_en[g*8 +: 8] = {8{lane_en[g]}};
    end

    assign do_wr     = bus_sel && bus_we && aligned;
    assign do_rd     = bus_sel && !bus_we && aligned;
    assign open_bits = bit_en & ~st_q.mask;
    assign pin_view  = (st_q.dir & st_q.outl) | (~st_q.dir & pin_sync);

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (do_wr) begin
            case (reg_idx)
                IDX_W'(IDX_DIR):  st_d.dir  = (st_q.dir & ~bit_en) | (bus_wdata & bit_en);
                IDX_W'(IDX_MASK): st_d.mask = (st_q.mask & ~bit_en) | (bus_wdata & bit_en);
                IDX_W'(IDX_PIN):  st_d.outl = (st_q.outl & ~open_bits) | (bus_wdata & open_bits);
                IDX_W'(IDX_SET):  st_d.outl = st_q.outl | (bus_wdata & open_bits);
                IDX_W'(IDX_CLR):  st_d.outl = st_q.outl & ~(bus_wdata & open_bits);
                default:          st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read path, zero wait states, lanes kept in position
    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            case (reg_idx)
                IDX_W'(IDX_DIR):  bus_rdata = st_q.dir & bit_en;
                IDX_W'(IDX_MASK): bus_rdata = st_q.mask & bit_en;
                IDX_W'(IDX_PIN):  bus_rdata = pin_view & open_bits;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign pad_out   = st_q.outl;
    assign pad_oe    = st_q.dir;
    assign mask_view = st_q.mask;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
    import gpio_port_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      mask_view
);

    localparam int OFS_W = $clog2(W / 8);
    localparam int IDX_W = ADDR_W - OFS_W;

    logic [IDX_W-1:0] idx;
    logic             word_wr;
    logic             latch_wr;

    assign idx      = bus_addr[ADDR_W-1:OFS_W];
    assign word_wr  = bus_sel && bus_we && (bus_size == SZ_WORD) && (bus_addr[OFS_W-1:0] == '0);
    assign latch_wr = bus_sel && bus_we &&
                      (idx == IDX_W'(IDX_PIN) || idx == IDX_W'(IDX_SET) || idx == IDX_W'(IDX_CLR));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0 && mask_view == '0));

    // R4
    dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && idx == IDX_W'(IDX_DIR)) |=> (pad_oe == $past(bus_wdata)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R6
    set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && idx == IDX_W'(IDX_SET)) |=>
        ((pad_out & $past(bus_wdata & ~mask_view)) == $past(bus_wdata & ~mask_view)));

    // R7
    clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && idx == IDX_W'(IDX_CLR)) |=>
        ((pad_out & $past(bus_wdata & ~mask_view)) == '0));

    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_wr |=> (((pad_out ^ $past(pad_out)) & $past(mask_view)) == '0));

    // R9
    masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && idx == IDX_W'(IDX_PIN)) |-> ((bus_rdata & mask_view) == '0));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(LANES * 8), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .mask_view (mask_view)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;

    localparam int W = 32;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2;
    localparam logic [1:0] B = 2'd0, H = 2'd1, WD = 2'd2;
    localparam logic [W-1:0] PAD_A = 32'hA5C3_0F96;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{OP_W, 5'h00, WD, 32'hFFFF_0000, 4'd4},  // R4 upper pins outputs
        '{OP_R, 5'h00, WD, 32'hFFFF_0000, 4'd4},  // R4
        '{OP_W, 5'h14, WD, 32'h1234_5678, 4'd5},  // R5
        '{OP_R, 5'h14, WD, 32'h1234_0F96, 4'd9},  // R9 outputs latch, inputs pad
        '{OP_R, 5'h17, B,  32'h1200_0000, 4'd2},  // R2 byte lane 3
        '{OP_R, 5'h16, H,  32'h1234_0000, 4'd2},  // R2 upper half
        '{OP_W, 5'h16, B,  32'h00AB_0000, 4'd2},  // R2 byte write lane 2
        '{OP_R, 5'h14, WD, 32'h12AB_0F96, 4'd2},  // R2
        '{OP_W, 5'h10, WD, 32'hFF00_0000, 4'd4},  // R4 mask top byte
        '{OP_R, 5'h10, WD, 32'hFF00_0000, 4'd4},  // R4
        '{OP_W, 5'h14, WD, 32'hFFFF_FFFF, 4'd8},  // R8
        '{OP_P, 5'h00, WD, 32'h12FF_FFFF, 4'd8},  // R8 top byte frozen
        '{OP_R, 5'h14, WD, 32'h00FF_0F96, 4'd9},  // R9 masked reads 0
        '{OP_W, 5'h1C, WD, 32'hFFFF_FFFF, 4'd7},  // R7
        '{OP_P, 5'h00, WD, 32'h1200_0000, 4'd7},  // R7
        '{OP_W, 5'h1A, H,  32'h0F0F_0000, 4'd6},  // R6 set upper half
        '{OP_P, 5'h00, WD, 32'h120F_0000, 4'd6},  // R6
        '{OP_W, 5'h10, WD, 32'h0000_0000, 4'd4},  // R4 clear mask
        '{OP_R, 5'h14, WD, 32'h120F_0F96, 4'd9},  // R9
        '{OP_W, 5'h15, H,  32'hFFFF_FFFF, 4'd3},  // R3 odd half-word
        '{OP_R, 5'h14, WD, 32'h120F_0F96, 4'd3},  // R3
        '{OP_R, 5'h15, H,  32'h0000_0000, 4'd3},  // R3 misaligned read
        '{OP_W, 5'h14, 2'd3, 32'hFFFF_FFFF, 4'd3},// R3 invalid size
        '{OP_R, 5'h14, WD, 32'h120F_0F96, 4'd3},  // R3
        '{OP_R, 5'h18, WD, 32'h0000_0000, 4'd10}, // R10 set reads 0
        '{OP_W, 5'h0C, WD, 32'hDEAD_BEEF, 4'd10}, // R10 unmapped write
        '{OP_R, 5'h0C, WD, 32'h0000_0000, 4'd10}, // R10
        '{OP_W, 5'h00, B,  32'h0000_00FF, 4'd2},  // R2 direction byte 0
        '{OP_R, 5'h00, WD, 32'hFFFF_00FF, 4'd2},  // R2
        '{OP_R, 5'h14, WD, 32'h120F_0F00, 4'd9},  // R9
        '{OP_R, 5'h14, H,  32'h0000_0F00, 4'd2}   // R2 lower half
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_port_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input int rq, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] s);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
        bus_size = s;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        check(1, pad_out, '0);
        check(1, pad_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h10, WD);
        check(1, bus_rdata, '0);
        rd(5'h14, WD);
        check(1, bus_rdata, '0);
        bus_sel = 1'b0;
        pad_in = PAD_A;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr  = VECS[i].addr;
            bus_size  = VECS[i].size;
            bus_wdata = VECS[i].data;
            case (VECS[i].op)
                OP_W: begin bus_sel = 1'b1; bus_we = 1'b1; end
                OP_R: begin bus_sel = 1'b1; bus_we = 1'b0; #1; check(int'(VECS[i].rq), bus_rdata, VECS[i].data); end
                default: begin bus_sel = 1'b0; bus_we = 1'b0; #1; check(int'(VECS[i].rq), pad_out, VECS[i].data); end
            endcase
        end

        // R9 synchroniser latency: pins 8-15 are inputs
        @(negedge clk);
        bus_we = 1'b0;
        pad_in = 32'h0000_F000;
        rd(5'h14, H);
        check(9, bus_rdata, 32'h0000_0F00);
        @(negedge clk); #1;
        check(9, bus_rdata, 32'h0000_0F00);   // R9 one edge: still old
        @(negedge clk); #1;
        check(9, bus_rdata, 32'h0000_F000);   // R9 two edges: new level
        check(4, pad_oe, 32'hFFFF_00FF);      // R4
        check(5, pad_out, 32'h120F_0000);     // R5 latch unchanged by reads

        // R1 asynchronous reset mid-run
        @(negedge clk);
        bus_sel = 1'b0;
        rst_n = 1'b0;
        #1;
        check(1, pad_out, '0);
        check(1, pad_oe, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(5'h10, WD);
        check(1, bus_rdata, '0);
        bus_sel = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule